// File: doc/BRIEF.md
# Posted-Write Queue with Read Bypass

This block sits between a cache controller and the next level of memory. Stores that the cache passes on, whether write-through stores or dirty lines being evicted, are parked in a small first-in first-out queue. The processor side does not have to wait for memory to accept them. Reads that miss in the cache are allowed to reach memory before these parked writes. This shortens the miss penalty seen by the processor.

Reads can only overtake writes when it is safe. Every read address is compared at the same time against each occupied queue slot, and also against a write being enqueued in the same cycle. With no match, the read takes the memory port at once. With a match, the queue keeps draining in order until the matching entry has gone out, and only then is the read issued. The queue otherwise drains whenever no issuable read is waiting for the port.

An eviction is handled by presenting the dirty line on the write port in the same cycle as the fill read. The line is parked, the fill read goes out first, and the write follows later. Read data from memory is passed straight to the requester, so the processor resumes without waiting for any queued write.

Top module: `wrq_bypass`

## Requirements
- R1: After reset the queue is empty, `wr_full` is low, and neither a memory request nor a read response is presented.
- R2: A write is accepted in any cycle where `wr_valid` is high and `wr_full` is low. `wr_full` is high exactly when DEPTH (default 4) entries are held. A write presented while `wr_full` is high is dropped and never reaches memory.
- R3: A read request is presented on the memory port in the same cycle, with `mem_write` low, when three conditions hold: `rd_req_valid` is high, no read is outstanding, and its address matches no held entry. It takes the port ahead of any queued write.
- R4: The address match covers every occupied entry and also a write accepted in the same cycle. A read whose address equals that of a same-cycle accepted write is not issued in that cycle.
- R5: While a read matches, the queue drains oldest-first. The read is issued only in the cycle after its last matching entry has been accepted by memory, so the read observes that data.
- R6: Queued writes leave on the memory port (`mem_write` high) in arrival order. An entry is removed only in a cycle where `mem_ready` is high. Draining happens only when no issuable read is waiting.
- R7: `rd_resp_valid`/`rd_resp_data` follow `mem_rvalid`/`mem_rdata` in the same cycle. The returned data equals the most recent write to that address accepted before the read was issued, or the memory's original contents if no such write exists.
- R8: At most one read is outstanding. `rd_req_ready` stays low from read acceptance until `mem_rvalid`, and queued writes may still drain in that window.
- R9: A write and a read to a different address presented together are both accepted in that cycle. The read is on the port and the write is parked for later.
- R10: A cycle that both drains one entry and accepts one write leaves the occupancy unchanged. The new entry keeps its place behind the older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write (store or evicted line) presented |
| wr_addr | input | AW | Line address of the write |
| wr_data | input | DW | Line data of the write |
| wr_full | output | 1 | Queue holds DEPTH entries; writes are refused |
| rd_req_valid | input | 1 | Read miss request presented, held until accepted |
| rd_req_addr | input | AW | Line address of the read |
| rd_req_ready | output | 1 | Read accepted by memory this cycle |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| mem_valid | output | 1 | Memory request presented |
| mem_write | output | 1 | 1 = write from queue head, 0 = read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Write data for a memory write |
| mem_ready | input | 1 | Memory accepts the presented request |
| mem_rvalid | input | 1 | Memory returns read data |
| mem_rdata | input | DW | Returned read data |

## Verification
Two functions can land in one cycle. One pair is parking an evicted line on the write port while the fill read takes the memory port. The other is draining the queue head while a new write is enqueued. The bench presents the write and the read together, both with differing and with equal addresses. It judges the outcome from which request appears on the memory port and whether `rd_req_ready` rises. It also drives an enqueue into a cycle where `mem_ready` retires the head, and then checks which address leads the next write. A reference queue is then run against long stretches of mixed traffic over eight addresses with random `mem_ready`. These coincidences recur often, and every returned read is compared with the last value the requester wrote.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
   typedef enum logic [1:0] {
      PORT_IDLE  = 2'd0,
      PORT_READ  = 2'd1,
      PORT_DRAIN = 2'd2
   } port_sel_e;
endpackage

// File: rtl/wrq_store.sv
module wrq_store #(
   parameter int DEPTH = 4,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic [AW-1:0] look_addr,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic          hit,
   output logic          full,
   output logic          empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("wrq_store: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_width_bad
      $error("wrq_store: AW and DW must be positive");
   end

   logic [AW-1:0]    slot_addr [DEPTH];
   logic [DW-1:0]    slot_data [DEPTH];
   logic [DEPTH-1:0] slot_vld;
   logic [DEPTH-1:0] slot_hit;
   logic [PW-1:0]    wp, rp;
   logic [CW-1:0]    occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         occ      <= '0;
         slot_vld <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
         for (int i = 0; i < DEPTH; i++) begin
            if (push && wp == PW'(i))     slot_vld[i] <= 1'b1;
            else if (pop && rp == PW'(i)) slot_vld[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         slot_addr[wp] <= push_addr;
         slot_data[wp] <= push_data;
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign slot_hit[gi] = slot_vld[gi] && (slot_addr[gi] == look_addr);
   end

   assign hit       = |slot_hit;
   assign head_addr = slot_addr[rp];
   assign head_data = slot_data[rp];
   assign full      = (occ == CW'(DEPTH));
   assign empty     = (occ == '0);

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R10
   occ_tracks_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_vld) == int'(occ));
   // R10
   swap_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> occ == $past(occ));
endmodule

// File: rtl/wrq_port_arb.sv
module wrq_port_arb #(
   parameter int AW                = 8,
   parameter int DW                = 32,
   parameter bit DRAIN_DURING_BUSY = 1'b1
) (
   input  logic                rd_req_valid,
   input  logic [AW-1:0]       rd_req_addr,
   input  logic                rd_busy,
   input  logic                conflict,
   input  logic                q_empty,
   input  logic [AW-1:0]       head_addr,
   input  logic [DW-1:0]       head_data,
   input  logic                mem_ready,
   output wrq_pkg::port_sel_e  sel,
   output logic                mem_valid,
   output logic                mem_write,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   output logic                rd_take,
   output logic                q_pop
);
   import wrq_pkg::*;

   logic rd_wait;
   logic drain_ok;

   assign rd_wait = rd_req_valid && !rd_busy;

   if (DRAIN_DURING_BUSY) begin : g_drain_busy
      assign drain_ok = !q_empty && (!rd_wait || conflict);
   end else begin : g_drain_idle
      assign drain_ok = !q_empty && !rd_busy && (!rd_req_valid || conflict);
   end

   always_comb begin
      sel = PORT_IDLE;
      if (rd_wait && !conflict) sel = PORT_READ;
      else if (drain_ok)        sel = PORT_DRAIN;
   end

   always_comb begin
      mem_valid = (sel != PORT_IDLE);
      mem_write = (sel == PORT_DRAIN);
      mem_addr  = (sel == PORT_DRAIN) ? head_addr : rd_req_addr;
      mem_wdata = head_data;
      rd_take   = (sel == PORT_READ)  && mem_ready;
      q_pop     = (sel == PORT_DRAIN) && mem_ready;
   end
endmodule

// File: rtl/wrq_bypass.sv
module wrq_bypass #(
   parameter int DEPTH             = 4,
   parameter int AW                = 8,
   parameter int DW                = 32,
   parameter bit RESP_REG          = 1'b0,
   parameter bit DRAIN_DURING_BUSY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          wr_full,
   input  logic          rd_req_valid,
   input  logic [AW-1:0] rd_req_addr,
   output logic          rd_req_ready,
   output logic          rd_resp_valid,
   output logic [DW-1:0] rd_resp_data,
   output logic          mem_valid,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   import wrq_pkg::*;

   logic          wr_take;
   logic          q_pop, q_hit, q_full, q_empty;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data;
   logic          conflict;
   logic          rd_busy;
   port_sel_e     sel;

   assign wr_take  = wr_valid && !q_full;
   assign wr_full  = q_full;
   assign conflict = q_hit || (wr_take && (wr_addr == rd_req_addr));

   wrq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(wr_take), .push_addr(wr_addr), .push_data(wr_data),
      .pop(q_pop), .look_addr(rd_req_addr),
      .head_addr(head_addr), .head_data(head_data),
      .hit(q_hit), .full(q_full), .empty(q_empty)
   );

   wrq_port_arb #(.AW(AW), .DW(DW), .DRAIN_DURING_BUSY(DRAIN_DURING_BUSY)) u_arb (
      .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
      .rd_busy(rd_busy), .conflict(conflict), .q_empty(q_empty),
      .head_addr(head_addr), .head_data(head_data), .mem_ready(mem_ready),
      .sel(sel), .mem_valid(mem_valid), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .rd_take(rd_req_ready), .q_pop(q_pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rd_busy <= 1'b0;
      else if (rd_req_ready) rd_busy <= 1'b1;
      else if (mem_rvalid)   rd_busy <= 1'b0;
   end

   if (RESP_REG) begin : g_resp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_resp_valid <= 1'b0;
            rd_resp_data  <= '0;
         end else begin
            rd_resp_valid <= mem_rvalid;
            if (mem_rvalid) rd_resp_data <= mem_rdata;
         end
      end
   end else begin : g_resp_pass
      assign rd_resp_valid = mem_rvalid;
      assign rd_resp_data  = mem_rdata;
   end

   // R3
   read_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_busy && !q_hit && !(wr_take && wr_addr == rd_req_addr))
      |-> (mem_valid && !mem_write && mem_addr == rd_req_addr));
   // R5
   conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && q_hit) |-> !rd_req_ready);
   // R8
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> !rd_req_ready);
   // R7
   resp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> rd_busy);
   // R9
   evict_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_take && rd_req_ready) |=> !q_empty);
endmodule

// File: tb/wrq_bypass_tb.sv
module wrq_bypass_tb;
   localparam int AW    = 8;
   localparam int DW    = 32;
   localparam int DEPTH = 4;
   localparam int LAT   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_full;
   logic          rd_req_valid = 1'b0;
   logic [AW-1:0] rd_req_addr = '0;
   logic          rd_req_ready;
   logic          rd_resp_valid;
   logic [DW-1:0] rd_resp_data;
   logic          mem_valid, mem_write;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ready = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #2 clk = ~clk;

   wrq_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

   int checks = 0;
   int fails  = 0;

   // staged stimulus
   logic          s_wr = 0, s_rd = 0, s_mr = 0;
   logic [AW-1:0] s_wa = '0, s_ra = '0;
   logic [DW-1:0] s_wd = '0;

   // reference model
   logic [AW-1:0] q_a[$];
   logic [DW-1:0] q_d[$];
   logic [DW-1:0] bmem [256];
   logic [DW-1:0] pgm  [256];
   bit            m_busy = 0;
   int            pend_cnt = 0;
   logic [DW-1:0] pend_val = '0;
   logic [DW-1:0] exp_rd = '0;
   bit            m_rd_acc = 0;
   int            mem_wr_seen = 0;
   bit            saw_a14 = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      bit wacc, rw, conf, rgo, drn;
      @(posedge clk);
      #1;
      wr_valid = s_wr; wr_addr = s_wa; wr_data = s_wd;
      rd_req_valid = s_rd; rd_req_addr = s_ra; mem_ready = s_mr;
      mem_rvalid = 1'b0;
      if (pend_cnt > 0) begin
         pend_cnt--;
         if (pend_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = pend_val;
         end
      end
      @(negedge clk);
      wacc = s_wr && (q_a.size() < DEPTH);
      rw   = s_rd && !m_busy;
      conf = wacc && (s_wa == s_ra);
      foreach (q_a[i]) if (q_a[i] == s_ra) conf = 1;
      rgo  = rw && !conf;
      drn  = (q_a.size() > 0) && (!rw || conf);
      chk(wr_full == (q_a.size() == DEPTH), "R2", "wr_full", wr_full, q_a.size() == DEPTH);
      chk(mem_valid == (rgo || drn), rgo ? "R3" : "R6", "mem_valid", mem_valid, rgo || drn);
      if (rgo) begin
         chk(!mem_write && mem_addr == s_ra, "R3", "read on port", {mem_write, mem_addr}, {1'b0, s_ra});
      end else if (drn) begin
         chk(mem_write && mem_addr == q_a[0] && mem_wdata == q_d[0], "R6", "drain head",
             {mem_write, mem_addr, mem_wdata}, {1'b1, q_a[0], q_d[0]});
      end
      chk(rd_req_ready == (rgo && s_mr), m_busy ? "R8" : (conf ? "R5" : "R3"),
          "rd_req_ready", rd_req_ready, rgo && s_mr);
      chk(rd_resp_valid == mem_rvalid, "R7", "rd_resp_valid", rd_resp_valid, mem_rvalid);
      if (mem_rvalid)
         chk(rd_resp_data == exp_rd, "R7", "read data", rd_resp_data, exp_rd);
      if (mem_valid && mem_write && mem_ready) begin
         mem_wr_seen++;
         if (mem_addr == 8'd14) saw_a14 = 1;
      end
      // advance model to next edge
      if (mem_rvalid) m_busy = 0;
      m_rd_acc = rgo && s_mr;
      if (m_rd_acc) begin
         m_busy   = 1;
         pend_cnt = LAT;
         pend_val = bmem[s_ra];
         exp_rd   = pgm[s_ra];
      end
      if (drn && !rgo && s_mr) begin
         bmem[q_a[0]] = q_d[0];
         void'(q_a.pop_front());
         void'(q_d.pop_front());
      end
      if (wacc) begin
         q_a.push_back(s_wa);
         q_d.push_back(s_wd);
         pgm[s_wa] = s_wd;
      end
   endtask

   task automatic idle(input int n);
      s_wr = 0; s_rd = 0; s_mr = 1;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int wcnt;
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 32'hA5A5_0000 ^ (i * 32'h0101_0101);
         pgm[i]  = bmem[i];
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!wr_full && !mem_valid && !rd_resp_valid && !rd_req_ready, "R1", "reset outputs",
          {wr_full, mem_valid, rd_resp_valid, rd_req_ready}, 4'b0);

      // R2: fill with memory stalled, then one refused write
      s_mr = 0; s_rd = 0;
      for (int i = 0; i < DEPTH; i++) begin
         s_wr = 1; s_wa = AW'(10 + i); s_wd = 32'h1000 + i;
         step();
      end
      s_wr = 0; step();
      chk(wr_full == 1'b1, "R2", "full after DEPTH writes", wr_full, 1);
      s_wr = 1; s_wa = 8'd14; s_wd = 32'hDEAD; step();
      // R3: read bypasses full queue
      s_wr = 0; s_rd = 1; s_ra = 8'd20; s_mr = 1; step();
      chk(mem_valid && !mem_write && mem_addr == 8'd20 && rd_req_ready, "R3", "bypass read",
          {mem_valid, mem_write, mem_addr}, {1'b1, 1'b0, 8'd20});
      mem_wr_seen = 0;
      idle(12);
      chk(mem_wr_seen == DEPTH, "R2", "writes reaching memory", mem_wr_seen, DEPTH);
      chk(!saw_a14, "R2", "refused write absent", saw_a14, 0);

      // R5: conflicting read waits for matching entry
      s_mr = 0; s_rd = 0;
      for (int i = 0; i < DEPTH; i++) begin
         s_wr = 1; s_wa = AW'(30 + i); s_wd = 32'h3000 + i;
         step();
      end
      s_wr = 0; s_rd = 1; s_ra = 8'd32; s_mr = 1;
      mem_wr_seen = 0;
      step();
      chk(mem_write && mem_addr == 8'd30 && !rd_req_ready, "R5", "oldest drains first",
          {mem_write, mem_addr}, {1'b1, 8'd30});
      wcnt = 0;
      while (!m_rd_acc && wcnt < 20) begin step(); wcnt++; end
      s_rd = 0;
      chk(mem_wr_seen == 3, "R5", "writes before read", mem_wr_seen, 3);
      idle(8);

      // R4: same-cycle write to the read address blocks the read
      s_wr = 1; s_wa = 8'd40; s_wd = 32'h4040; s_rd = 1; s_ra = 8'd40; s_mr = 1;
      step();
      chk(!rd_req_ready && !mem_valid, "R4", "same-cycle match holds read",
          {rd_req_ready, mem_valid}, 2'b00);
      s_wr = 0; step();
      chk(mem_write && mem_addr == 8'd40, "R4", "matching write drains", {mem_write, mem_addr}, {1'b1, 8'd40});
      step();
      chk(rd_req_ready && !mem_write, "R4", "read after drain", {rd_req_ready, mem_write}, 2'b10);
      s_rd = 0; idle(6);

      // R9: eviction parked while fill read goes out
      s_wr = 1; s_wa = 8'd50; s_wd = 32'h5050; s_rd = 1; s_ra = 8'd51; s_mr = 1;
      step();
      chk(rd_req_ready && !mem_write && mem_addr == 8'd51, "R9", "fill read first",
          {rd_req_ready, mem_write, mem_addr}, {1'b1, 1'b0, 8'd51});
      s_wr = 0; s_rd = 0; step();
      chk(mem_valid && mem_write && mem_addr == 8'd50, "R9", "parked line drains later",
          {mem_valid, mem_write, mem_addr}, {1'b1, 1'b1, 8'd50});
      idle(6);

      // R10: drain and enqueue in one cycle
      s_mr = 0; s_wr = 1; s_wa = 8'd60; s_wd = 32'h6060; step();
      s_mr = 1; s_wa = 8'd61; s_wd = 32'h6161; step();
      s_wr = 0; s_mr = 0; step();
      chk(mem_write && mem_addr == 8'd61 && !wr_full, "R10", "new entry at head",
          {mem_write, mem_addr}, {1'b1, 8'd61});
      idle(4);

      // mixed traffic over eight addresses
      for (int c = 0; c < 3000; c++) begin
         if (!s_rd || m_rd_acc) begin
            s_rd = ($urandom_range(0, 2) == 0);
            s_ra = AW'($urandom_range(0, 7));
         end
         s_wr = ($urandom_range(0, 1) == 1);
         s_wa = AW'($urandom_range(0, 7));
         s_wd = $urandom();
         s_mr = ($urandom_range(0, 3) != 0);
         step();
      end
      s_rd = 0;
      idle(30);
      finish_run();
   end
endmodule